// File: doc/BRIEF.md
# Non-Revertive Reference Clock Selector

This block decides which of two reference clocks feeds a phase-locked loop. It produces the select line of an external two-input clock multiplexer, together with an acknowledge output that reports the input in use. It runs on a free-running system clock. Its control inputs are a manual select pin, an auto-enable pin and the PLL loss-of-lock status. All three pass through two-flop synchronizers before the block uses them.

With auto-enable low, the block is in manual mode and the active input follows the manual select pin. When auto-enable goes high, the input selected at that moment becomes the starting input, and the manual pin is then ignored. In auto mode, loss of lock is first qualified: it must stay high for a set number of consecutive cycles. A qualified fault makes the block move to the other input and start a holdoff window. During that window fault detection is masked so that the PLL can lock again. The selection never returns to the earlier input unless that input is chosen as a fault response. As a result, the two inputs alternate only while lock cannot be reached on either of them.

The controller has three states. `ST_MANUAL` tracks the manual pin and moves to `ST_WATCH` when auto-enable is seen. `ST_WATCH` flips the active input on a qualified fault and moves to `ST_HOLD`. `ST_HOLD` returns to `ST_WATCH` once the holdoff expires. From either auto state the block goes back to `ST_MANUAL` when auto-enable drops.

Top module: `refsel_ctrl`

## Requirements
- R1: In manual mode (auto-enable low), the active input equals the manual select pin, with 1 meaning reference 1 and 0 meaning reference 0. It follows a pin change within three system clocks.
- R2: `ref_mux_sel` and `ref_ack` both report the active input: 1 for reference 1 and 0 for reference 0.
- R3: In manual mode, loss of lock has no effect on the selection.
- R4: On entry to auto mode, the current manual selection becomes the active input. While in auto mode, changes on the manual select pin are ignored.
- R5: Loss of lock counts as a fault only after it has been high for `QUAL_CYCLES` consecutive synchronized cycles. A shorter pulse causes no switch.
- R6: In auto mode, a qualified fault switches the active input to the other reference.
- R7: Selection is non-revertive: after a switch, the block stays on the new input when loss of lock clears.
- R8: For `HOLDOFF_CYCLES` cycles after a switch, fault detection is masked. If loss of lock persists, the next switch comes exactly `HOLDOFF_CYCLES + QUAL_CYCLES` clocks after the previous one.
- R9: Synchronous reset gives manual mode, reference 0 active, the holdoff cleared and the synchronizers cleared.
- R10: When auto-enable is dropped, the active input follows the manual select pin again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| lol_in | input | 1 | PLL loss-of-lock status, 1 = not locked (asynchronous) |
| auto_en_in | input | 1 | Automatic reselection enable (asynchronous) |
| man_sel_in | input | 1 | Manual reference select (asynchronous) |
| ref_mux_sel | output | 1 | Select line of the reference clock multiplexer |
| ref_ack | output | 1 | Acknowledge: reference currently in use |

## Verification
The bench targets the qualification boundary. A loss-of-lock pulse one cycle shorter than the threshold must leave the selection alone, and a pulse exactly at the threshold must switch it. A counter that is off by one fails one of these two checks. With loss of lock held on both inputs, the bench times the second switch to the exact cycle, which exposes a holdoff that is too short or is never enforced. It toggles the manual pin during auto mode and clears loss of lock after a switch, to catch a design that still listens to the pin or that reverts. A reset issued mid-way through auto mode must return the selection to input 0 on the next clock.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    typedef enum logic [1:0] {
        ST_MANUAL = 2'd0,
        ST_WATCH  = 2'd1,
        ST_HOLD   = 2'd2
    } sel_state_e;
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/refsel_fault_qual.sv
module refsel_fault_qual #(
    parameter int QUAL_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic lol,
    output logic fault
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);
    localparam logic [CW-1:0] TOP  = CW'(QUAL_CYCLES);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !lol) run_q <= '0;
        else if (run_q != TOP)  run_q <= run_q + 1'b1;
    end

    assign fault = !clr && lol && (run_q == LAST);

    generate
        if (QUAL_CYCLES > 1) begin : g_glitch_chk
            // R5
            glitch_reject_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(lol) |-> !fault);
        end
    endgenerate
endmodule

// File: rtl/refsel_holdoff.sv
module refsel_holdoff #(
    parameter int HOLDOFF_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int HW = (HOLDOFF_CYCLES > 1) ? $clog2(HOLDOFF_CYCLES) : 1;
    localparam logic [HW-1:0] START = HW'(HOLDOFF_CYCLES - 1);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (load)          left_q <= START;
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign done = (left_q == '0);
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int QUAL_CYCLES    = 16,
    parameter int HOLDOFF_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic lol_in,
    input  logic auto_en_in,
    input  logic man_sel_in,
    output logic ref_mux_sel,
    output logic ref_ack
);
    logic [2:0] raw_in, sync_out;
    logic       lol_s, auto_s, man_s;
    logic       fault, hold_done, qual_clr, hold_load;

    sel_state_e state_q, state_d;
    logic       active_q, active_d;

    assign raw_in = {lol_in, auto_en_in, man_sel_in};

    refsel_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
    );
    assign {lol_s, auto_s, man_s} = sync_out;

    refsel_fault_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk(clk), .rst(rst), .clr(qual_clr), .lol(lol_s), .fault(fault)
    );

    refsel_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_hold (
        .clk(clk), .rst(rst), .load(hold_load), .done(hold_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_MANUAL;
            active_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            active_q <= active_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        active_d = active_q;
        unique case (state_q)
            ST_MANUAL: begin
                active_d = man_s;
                if (auto_s) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (!auto_s) begin
                    state_d  = ST_MANUAL;
                    active_d = man_s;
                end else if (fault) begin
                    state_d  = ST_HOLD;
                    active_d = !active_q;
                end
            end
            ST_HOLD: begin
                if (!auto_s) begin
                    state_d  = ST_MANUAL;
                    active_d = man_s;
                end else if (hold_done) begin
                    state_d = ST_WATCH;
                end
            end
            default: begin
                state_d  = ST_MANUAL;
                active_d = 1'b0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ref_mux_sel = active_q;
        ref_ack     = active_q;
        qual_clr    = (state_q != ST_WATCH);
        hold_load   = (state_q == ST_WATCH) && auto_s && fault;
    end

    // R1
    manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MANUAL) |=> (active_q == $past(man_s)));
    // R4
    auto_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MANUAL && auto_s) |=> (state_q == ST_WATCH));
    // R7
    no_revert_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_MANUAL && auto_s && !fault) |=> $stable(active_q));
    // R6
    fault_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WATCH && auto_s && fault)
        |=> (state_q == ST_HOLD && active_q != $past(active_q)));
    // R8
    holdoff_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> !fault);
    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_q == ST_MANUAL && !active_q && hold_done));
endmodule

// File: tb/tb_refsel_ctrl.sv
`timescale 1ns/1ps
module tb_refsel_ctrl;
    localparam int QC = 4;
    localparam int HC = 8;

    logic clk = 1'b0;
    logic rst, lol_in, auto_en_in, man_sel_in;
    logic ref_mux_sel, ref_ack;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    refsel_ctrl #(.QUAL_CYCLES(QC), .HOLDOFF_CYCLES(HC)) dut (
        .clk(clk), .rst(rst), .lol_in(lol_in), .auto_en_in(auto_en_in),
        .man_sel_in(man_sel_in), .ref_mux_sel(ref_mux_sel), .ref_ack(ref_ack)
    );

    typedef struct packed {
        logic       auto_en;
        logic       man;
        logic       lol;
        logic [7:0] cycles;
        logic       exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'd6,  1'b0},  // R1
        '{1'b0, 1'b1, 1'b0, 8'd6,  1'b1},  // R1
        '{1'b0, 1'b1, 1'b1, 8'd20, 1'b1},  // R3
        '{1'b0, 1'b0, 1'b0, 8'd6,  1'b0},  // R1
        '{1'b0, 1'b1, 1'b0, 8'd6,  1'b1},  // R1
        '{1'b1, 1'b1, 1'b0, 8'd6,  1'b1},  // R4 entry
        '{1'b1, 1'b0, 1'b0, 8'd6,  1'b1},  // R4 pin ignored
        '{1'b1, 1'b0, 1'b1, 8'd8,  1'b0},  // R6
        '{1'b1, 1'b0, 1'b0, 8'd20, 1'b0},  // R7
        '{1'b0, 1'b0, 1'b0, 8'd6,  1'b0},  // R10
        '{1'b0, 1'b1, 1'b0, 8'd6,  1'b1}   // R10
    };

    function automatic string row_req(int i);
        case (i)
            2:       return "R3";
            5, 6:    return "R4";
            7:       return "R6";
            8:       return "R7";
            9, 10:   return "R10";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        n_run++;
        if (ref_ack !== exp || ref_mux_sel !== exp) begin
            n_fail++;
            $display("FAIL %s: ack=%b sel=%b expected %b", req, ref_ack, ref_mux_sel, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic prev;
        int   guard;
        rst = 1'b1; lol_in = 1'b0; auto_en_in = 1'b0; man_sel_in = 1'b0;
        wait_neg(3);
        check("R9", 1'b0);            // reset state
        check("R2", 1'b0);
        rst = 1'b0;
        wait_neg(1);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            auto_en_in = VECS[i].auto_en;
            man_sel_in = VECS[i].man;
            lol_in     = VECS[i].lol;
            wait_neg(int'(VECS[i].cycles));
            check(row_req(i), VECS[i].exp);
        end

        // R5: qualification boundary, active currently 1 in manual
        auto_en_in = 1'b1; man_sel_in = 1'b0;
        wait_neg(6);
        check("R4", 1'b0);
        lol_in = 1'b1; wait_neg(QC - 1); lol_in = 1'b0;
        wait_neg(10);
        check("R5", 1'b0);            // short pulse rejected
        lol_in = 1'b1; wait_neg(QC); lol_in = 1'b0;
        wait_neg(10);
        check("R5", 1'b1);            // exact threshold switches
        wait_neg(HC + 4);
        check("R7", 1'b1);

        // R8: persistent fault, alternation timing
        lol_in = 1'b1;
        prev  = ref_ack;
        guard = 0;
        while (ref_ack === prev && guard < 100) begin
            wait_neg(1);
            guard++;
        end
        check("R6", !prev);
        wait_neg(HC + QC - 1);
        check("R8", !prev);           // still masked / qualifying
        wait_neg(1);
        check("R8", prev);            // second switch exactly on time
        lol_in = 1'b0;
        wait_neg(HC + 10);

        // R9: reset in the middle of auto mode
        man_sel_in = 1'b1;
        rst = 1'b1;
        wait_neg(1);
        check("R9", 1'b0);
        rst = 1'b0;
        auto_en_in = 1'b0; man_sel_in = 1'b1;
        wait_neg(6);
        check("R1", 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule